// File: doc/BRIEF.md
# Receive Character Queue with Error Status

This block sits between a serial receiver and a processor read port. The receiver pushes each assembled character into the block, together with three condition bits: parity error, framing error and line break. The processor reads the character at the head of a three-slot queue. A data read pops that character. Reading the status outputs never pops the queue.

The block reports error conditions in one of two ways. In per-character mode it shows the condition bits of the head character only. In accumulate mode it shows the OR of the bits of every character that has been at the head since the last error-clear command. A push into a full queue is dropped and sets a sticky overrun flag.

A receiver reset command puts the read and write pointers back to slot zero and empties the queue. It does not wipe the storage, so the read port goes on showing whatever the slot under the read pointer holds. The block can also throttle the remote sender through an active-low request-to-send output. When a start bit is seen while the queue is full, that output is raised, and it drops again once a slot is free.

Top module: `rx_err_fifo`

## Requirements
- R1: After `rst_n` is low, `dataReady`, `full`, `overrun`, `rtsN`, `parErr`, `frmErr` and `brkErr` are all 0.
- R2: The queue holds at most 3 characters. `dataReady` is 1 when 1 or more are held, and `full` is 1 when 3 are held.
- R3: Characters leave in arrival order. `rdData` always shows the byte in the slot under the read pointer, and a `popRead` pulse moves on to the next slot.
- R4: When `blockMode` is 0, `parErr`, `frmErr` and `brkErr` are the condition bits stored with the head character. All three are 0 when the queue is empty.
- R5: When `blockMode` is 1, the three flags are the OR of the condition bits of every character that has been at the head since the last `errReset` pulse, including the current head.
- R6: The queue changes only on a push, a `popRead` pulse or a `rxReset` pulse. With none of these, `dataReady` and `rdData` hold their values.
- R7: A `rxReset` pulse makes the queue empty (`dataReady` is 0) and sets both pointers to slot 0. It keeps the stored bytes, so `rdData` then shows the old contents of slot 0.
- R8: A `popRead` pulse on an empty queue still moves the read pointer. Later reads are then misaligned and return stale bytes until the next `rxReset`.
- R9: A push while the queue is full and no pop happens in the same cycle is discarded and sets `overrun`. `overrun` stays 1 until an `errReset` pulse.
- R10: With `autoFlow` at 1, a `startSeen` pulse while the queue is full sets `rtsN` to 1 on the next cycle. `rtsN` returns to 0 one cycle after the queue stops being full. With `autoFlow` at 0, `rtsN` is 0.
- R11: A character's condition bits appear on the flag outputs no later than the cycle in which `dataReady` rises for that character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pushValid | input | 1 | Receiver delivers a character this cycle |
| pushData | input | 8 | Received byte |
| pushPar | input | 1 | Parity error seen on the delivered character |
| pushFrm | input | 1 | Framing error seen on the delivered character |
| pushBrk | input | 1 | Line break seen on the delivered character |
| startSeen | input | 1 | Receiver saw a valid start bit |
| popRead | input | 1 | Processor data read, pops the head |
| blockMode | input | 1 | 1: accumulated flags, 0: head-only flags |
| autoFlow | input | 1 | Enables automatic request-to-send control |
| rxReset | input | 1 | Receiver reset command |
| errReset | input | 1 | Error-clear command |
| rdData | output | 8 | Byte under the read pointer |
| dataReady | output | 1 | At least one character is held |
| full | output | 1 | All slots are held |
| overrun | output | 1 | Sticky dropped-push flag |
| parErr | output | 1 | Reported parity error |
| frmErr | output | 1 | Reported framing error |
| brkErr | output | 1 | Reported break |
| rtsN | output | 1 | Active-low request to send |

## Verification
The characters pushed carry a different condition bit each: parity only, framing only, break only, or none. This shows whether head-only reporting follows the head slot as it moves, and whether accumulate mode keeps bits from characters already popped. An error-clear issued while a flagged character is still at the head tells a cleared accumulator apart from the live head bits. Pops on an empty queue, followed by a fresh push and a receiver reset, show that the storage survives while the pointers move. Start-bit pulses are applied with the queue full and not full, and with flow control on and off, to separate the raise condition from the release condition.

// File: rtl/rx_fifo_pkg.sv
package rx_fifo_pkg;
  parameter int FIFO_DEPTH = 3;
  parameter int DATA_W = 8;
  localparam int PTR_W = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;

  typedef struct packed {
    logic brk;
    logic frm;
    logic par;
  } err_t;

  typedef struct packed {
    err_t err;
    logic [DATA_W-1:0] data;
  } entry_t;

  // strobes from control to datapath
  typedef struct packed {
    logic wrEn;
    logic [PTR_W-1:0] wrIdx;
    logic [PTR_W-1:0] rdIdx;
    logic headValid;
    logic accClr;
  } ctl_t;
endpackage

// File: rtl/rx_fifo_ctrl.sv
module rx_fifo_ctrl
  import rx_fifo_pkg::*;
#(
  parameter int DEPTH = FIFO_DEPTH
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pushValid,
  input  logic popRead,
  input  logic rxReset,
  input  logic errReset,
  input  logic startSeen,
  input  logic autoFlow,
  output ctl_t ctl,
  output logic dataReady,
  output logic full,
  output logic overrun,
  output logic rtsN
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic isFull, isEmpty, accept, drain;

  function automatic logic [PTR_W-1:0] stepPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  assign isFull  = (count == CNT_MAX);
  assign isEmpty = (count == '0);
  assign accept  = pushValid && (!isFull || popRead);
  assign drain   = popRead && !isEmpty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (rxReset) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (accept)  wrPtr <= stepPtr(wrPtr);
      if (popRead) rdPtr <= stepPtr(rdPtr);
      case ({accept, drain})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      overrun <= 1'b0;
    end else if (pushValid && isFull && !popRead && !rxReset) begin
      overrun <= 1'b1;
    end else if (errReset) begin
      overrun <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rtsN <= 1'b0;
    end else if (!autoFlow) begin
      rtsN <= 1'b0;
    end else if (isFull && startSeen) begin
      rtsN <= 1'b1;
    end else if (!isFull) begin
      rtsN <= 1'b0;
    end
  end

  always_comb begin
    ctl.wrEn      = accept && !rxReset;
    ctl.wrIdx     = wrPtr;
    ctl.rdIdx     = rdPtr;
    ctl.headValid = !isEmpty;
    ctl.accClr    = errReset;
  end

  assign dataReady = !isEmpty;
  assign full      = isFull;
endmodule

// File: rtl/rx_fifo_datapath.sv
module rx_fifo_datapath
  import rx_fifo_pkg::*;
#(
  parameter int DEPTH = FIFO_DEPTH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctl_t              ctl,
  input  entry_t            wrEntry,
  input  logic              blockMode,
  output logic [DATA_W-1:0] rdData,
  output err_t              flags
);
  entry_t slots [DEPTH];
  err_t   acc;
  err_t   headErr;
  entry_t headEntry;

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slots[s] <= '0;
      end else if (ctl.wrEn && (ctl.wrIdx == PTR_W'(s))) begin
        slots[s] <= wrEntry;
      end
    end
  end

  assign headEntry = slots[ctl.rdIdx];
  assign headErr   = ctl.headValid ? headEntry.err : '0;
  assign rdData    = headEntry.data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
    end else if (ctl.accClr) begin
      acc <= '0;
    end else begin
      acc <= acc | headErr;
    end
  end

  assign flags = blockMode ? (acc | headErr) : headErr;
endmodule

// File: rtl/rx_err_fifo.sv
module rx_err_fifo
  import rx_fifo_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pushValid,
  input  logic [7:0] pushData,
  input  logic       pushPar,
  input  logic       pushFrm,
  input  logic       pushBrk,
  input  logic       startSeen,
  input  logic       popRead,
  input  logic       blockMode,
  input  logic       autoFlow,
  input  logic       rxReset,
  input  logic       errReset,
  output logic [7:0] rdData,
  output logic       dataReady,
  output logic       full,
  output logic       overrun,
  output logic       parErr,
  output logic       frmErr,
  output logic       brkErr,
  output logic       rtsN
);
  ctl_t   ctl;
  entry_t wrEntry;
  err_t   flags;

  assign wrEntry = '{err: '{brk: pushBrk, frm: pushFrm, par: pushPar}, data: pushData};

  rx_fifo_ctrl #(.DEPTH(FIFO_DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .pushValid(pushValid), .popRead(popRead),
    .rxReset(rxReset), .errReset(errReset), .startSeen(startSeen),
    .autoFlow(autoFlow), .ctl(ctl), .dataReady(dataReady), .full(full),
    .overrun(overrun), .rtsN(rtsN)
  );

  rx_fifo_datapath #(.DEPTH(FIFO_DEPTH)) u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .wrEntry(wrEntry),
    .blockMode(blockMode), .rdData(rdData), .flags(flags)
  );

  assign parErr = flags.par;
  assign frmErr = flags.frm;
  assign brkErr = flags.brk;
endmodule

// File: rtl/rx_err_fifo_chk.sv
module rx_err_fifo_chk (
  input logic clk,
  input logic rst_n,
  input logic pushValid,
  input logic startSeen,
  input logic popRead,
  input logic blockMode,
  input logic autoFlow,
  input logic rxReset,
  input logic errReset,
  input logic dataReady,
  input logic full,
  input logic overrun,
  input logic parErr,
  input logic frmErr,
  input logic brkErr,
  input logic rtsN
);
  p_full_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> dataReady);

  p_empty_clean_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!blockMode && !dataReady) |-> (!parErr && !frmErr && !brkErr));

  p_hold_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dataReady && !popRead && !rxReset) |=> dataReady);

  p_realign_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rxReset |=> !dataReady);

  p_overrun_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (full && pushValid && !popRead && !rxReset) |=> overrun);

  p_overrun_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !errReset) |=> overrun);

  p_rts_raise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (autoFlow && full && startSeen) |=> rtsN);

  p_rts_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !autoFlow |=> !rtsN);
endmodule

bind rx_err_fifo rx_err_fifo_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pushValid(pushValid), .startSeen(startSeen),
  .popRead(popRead), .blockMode(blockMode), .autoFlow(autoFlow),
  .rxReset(rxReset), .errReset(errReset), .dataReady(dataReady),
  .full(full), .overrun(overrun), .parErr(parErr), .frmErr(frmErr),
  .brkErr(brkErr), .rtsN(rtsN)
);

// File: tb/tb_rx_err_fifo.sv
module tb_rx_err_fifo;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pushValid = 0, pushPar = 0, pushFrm = 0, pushBrk = 0;
  logic [7:0] pushData = '0;
  logic startSeen = 0, popRead = 0, blockMode = 0, autoFlow = 0;
  logic rxReset = 0, errReset = 0;
  logic [7:0] rdData;
  logic dataReady, full, overrun, parErr, frmErr, brkErr, rtsN;
  int nChecks = 0, nFails = 0;

  always #5 clk = ~clk;

  rx_err_fifo dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chkFlags(input string req, input int p, input int f, input int b);
    chk(req, {29'd0, brkErr, frmErr, parErr}, (b << 2) | (f << 1) | p);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic push(input logic [7:0] d, input logic p, input logic f, input logic b);
    pushValid = 1; pushData = d; pushPar = p; pushFrm = f; pushBrk = b;
    @(negedge clk);
    pushValid = 0; pushPar = 0; pushFrm = 0; pushBrk = 0;
  endtask

  task automatic pop();
    popRead = 1; @(negedge clk); popRead = 0;
  endtask

  task automatic rxRst();
    rxReset = 1; @(negedge clk); rxReset = 0;
  endtask

  task automatic errRst();
    errReset = 1; @(negedge clk); errReset = 0;
  endtask

  task automatic t_reset();
    chk("R1 dataReady", dataReady, 0);
    chk("R1 full", full, 0);
    chk("R1 overrun", overrun, 0);
    chk("R1 rtsN", rtsN, 0);
    chkFlags("R1 flags", 0, 0, 0);
  endtask

  task automatic t_fill_char();
    blockMode = 0;
    push(8'hA1, 1, 0, 0);
    chk("R11 ready with first", dataReady, 1);
    chkFlags("R11 flags with first", 1, 0, 0);
    chk("R2 not full at 1", full, 0);
    push(8'hB2, 0, 1, 0);
    push(8'hC3, 0, 0, 1);
    chk("R2 full at 3", full, 1);
    push(8'hD4, 0, 0, 0);
    chk("R9 overrun set", overrun, 1);
    chk("R9 still full", full, 1);
    chk("R3 head A1", rdData, 8'hA1);
    chkFlags("R4 head A1 flags", 1, 0, 0);
    pop();
    chk("R3 head B2", rdData, 8'hB2);
    chkFlags("R4 head B2 flags", 0, 1, 0);
    chk("R2 not full after pop", full, 0);
    pop();
    chk("R3 head C3 (D4 dropped)", rdData, 8'hC3);
    chkFlags("R4 head C3 flags", 0, 0, 1);
    pop();
    chk("R2 empty", dataReady, 0);
    chkFlags("R4 empty flags", 0, 0, 0);
    chk("R9 overrun sticky", overrun, 1);
    errRst();
    chk("R9 overrun cleared", overrun, 0);
  endtask

  task automatic t_hold();
    rxRst();
    push(8'h5A, 0, 0, 0);
    idle(4);
    chk("R6 ready held", dataReady, 1);
    chk("R6 data held", rdData, 8'h5A);
    pop();
  endtask

  task automatic t_block();
    rxRst(); errRst();
    blockMode = 1;
    push(8'h01, 1, 0, 0);
    push(8'h02, 0, 0, 0);
    chkFlags("R5 head par", 1, 0, 0);
    pop();
    chkFlags("R5 par kept after pop", 1, 0, 0);
    push(8'h03, 0, 1, 0);
    chkFlags("R5 frm not yet head", 1, 0, 0);
    pop();
    chkFlags("R5 par or frm", 1, 1, 0);
    errRst();
    chkFlags("R5 clear keeps live head", 0, 1, 0);
    pop();
    chkFlags("R5 popped head still counted", 0, 1, 0);
    errRst();
    chkFlags("R5 all cleared", 0, 0, 0);
    blockMode = 0;
  endtask

  task automatic t_stale();
    rxRst();
    push(8'h11, 0, 0, 0);
    push(8'h22, 1, 0, 0);
    rxRst();
    chk("R7 empty after reset", dataReady, 0);
    chk("R7 slot0 kept", rdData, 8'h11);
    chkFlags("R7 head flags cleared", 0, 0, 0);
    pop();
    chk("R8 empty pop no ready", dataReady, 0);
    chk("R8 pointer moved", rdData, 8'h22);
    push(8'h33, 0, 0, 0);
    chk("R8 ready after push", dataReady, 1);
    chk("R8 stale read", rdData, 8'h22);
    rxRst();
    chk("R7 realigned slot0", rdData, 8'h33);
  endtask

  task automatic t_rts();
    rxRst();
    autoFlow = 1;
    push(8'h41, 0, 0, 0);
    startSeen = 1; @(negedge clk); startSeen = 0;
    chk("R10 not full start", rtsN, 0);
    push(8'h42, 0, 0, 0);
    push(8'h43, 0, 0, 0);
    idle(1);
    chk("R10 full no start", rtsN, 0);
    startSeen = 1; @(negedge clk); startSeen = 0;
    chk("R10 raised", rtsN, 1);
    idle(2);
    chk("R10 held while full", rtsN, 1);
    pop();
    idle(1);
    chk("R10 released", rtsN, 0);
    push(8'h44, 0, 0, 0);
    autoFlow = 0;
    startSeen = 1; @(negedge clk); startSeen = 0;
    chk("R10 disabled", rtsN, 0);
    rxRst();
  endtask

  initial begin
    idle(2);
    t_reset();
    rst_n = 1;
    idle(1);
    t_fill_char();
    t_hold();
    t_block();
    t_stale();
    t_rts();
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    #200000;
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule